// File: doc/BRIEF.md
# Latched Interval Timer

A 16-bit down-counter paired with a separate 16-bit reload latch, reached through four byte-wide registers on a small register bus. Writing the high half of the counter starts a new time-out, built from that byte and the low latch. The latch-only registers let software set up the next period while the current one is still counting. Each time-out raises an interrupt flag. The timer can also drive a port pin as a single low pulse or as a square wave.

The block counts only in cycles where the clock enable `tick` is high. The mode input `free_run` picks single-shot operation (0) or automatic reload (1). The pin output is offered to the port logic as a level plus an override enable. The override is asserted only when both the timer pin enable and the pin's direction bit are set. A surrounding port block uses the override to choose between this level and its own output bit.

Top module: `latched_interval_timer`

## Requirements
- R1: Reset clears the flag, sets the pin level to 1 and leaves the timer disarmed. Reset does not change the counter or either latch.
- R2: A write to `sel`=0 or `sel`=2 stores the byte in the low latch only. A write to `sel`=3 stores the high latch only. None of these writes changes the counter.
- R3: A write to `sel`=1 stores the high latch and loads the counter with {written byte, low latch}. It arms the timer, clears the flag and drives the pin level to 0. Counting starts in the next enabled cycle.
- R4: Outside a load, the counter drops by one in each cycle with `tick`=1 and holds its value when `tick`=0.
- R5: An enabled cycle in which the armed counter is zero is a time-out. The flag is set at that edge. After a load of N, the flag appears N+1 enabled cycles after the load edge.
- R6: In single-shot mode (`free_run`=0), the pin returns to 1 at the time-out. The counter then continues through zero to FFFF and keeps counting. The flag is not set again until the next load.
- R7: In free-run mode (`free_run`=1), each time-out reloads all 16 counter bits from the latches, sets the flag and inverts the pin. Time-outs repeat every N+1 enabled cycles.
- R8: `rdata` shows the selected byte: 0 is the counter low byte, 1 the counter high byte, 2 the low latch and 3 the high latch. A read of `sel`=0 clears the flag. Reads of 1, 2 and 3 leave the flag unchanged.
- R9: A time-out in the same cycle as a clearing read leaves the flag set. A load in the same cycle as a time-out wins: the flag stays clear and the counter takes the new value.
- R10: `pin_ovr` is 1 exactly when `pin_en` and `pin_dir` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 2 | Register select (0 count low, 1 count high, 2 latch low, 3 latch high) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the selected register |
| free_run | input | 1 | 1 = reload on time-out, 0 = single shot |
| pin_en | input | 1 | Timer owns the pin when set |
| pin_dir | input | 1 | Direction bit of the pin (1 = output) |
| irq_flag | output | 1 | Time-out flag |
| pin_level | output | 1 | Timer pin level |
| pin_ovr | output | 1 | Pin override enable for the port logic |

## Verification
Two pairs of events can fall in the same cycle. A time-out can coincide with a clearing read of the counter low byte. A time-out can also coincide with a load through the high counter register. The bench loads a short count and steps the clock until the counter shows zero. It then places the read strobe, or the load write, on exactly the next edge. The flag and counter are judged against the R9 priority: the set survives the read, and the load overrides the time-out and yields the new count.

// File: rtl/lit_pkg.sv
package lit_pkg;
   typedef enum logic [1:0] {
      SEL_CNT_LO = 2'd0,
      SEL_CNT_HI = 2'd1,
      SEL_LAT_LO = 2'd2,
      SEL_LAT_HI = 2'd3
   } lit_sel_e;
endpackage

// File: rtl/lit_latch.sv
module lit_latch
   import lit_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  lit_sel_e          sel,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lat_lo,
   output logic [BYTE_W-1:0] lat_hi,
   output logic              load
);
   logic wr_lo, wr_hi;

   assign wr_lo = wr_en && (sel == SEL_CNT_LO || sel == SEL_LAT_LO);
   assign wr_hi = wr_en && (sel == SEL_CNT_HI || sel == SEL_LAT_HI);
   assign load  = wr_en && (sel == SEL_CNT_HI);

   // latches are deliberately not reset
   always_ff @(posedge clk) begin
      if (wr_lo) lat_lo <= wdata;
      if (wr_hi) lat_hi <= wdata;
   end
endmodule

// File: rtl/lit_core.sv
module lit_core #(
   parameter int CNT_W    = 16,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             free_run,
   input  logic             rd_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag,
   output logic             pin
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q, pin_q, flag_q, flag_d;
   logic             timeout;

   assign timeout = tick && !load && armed_q && (cnt_q == '0);

   // counter has no reset
   always_ff @(posedge clk) begin
      if (load)
         cnt_q <= load_val;
      else if (tick) begin
         if (timeout && free_run) cnt_q <= reload_val;
         else                     cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pin_q   <= 1'b1;
      end else if (load) begin
         armed_q <= 1'b1;
         pin_q   <= 1'b0;
      end else if (timeout) begin
         if (free_run) pin_q <= ~pin_q;
         else begin
            pin_q   <= 1'b1;
            armed_q <= 1'b0;
         end
      end
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb begin
            if (load)         flag_d = 1'b0;
            else if (timeout) flag_d = 1'b1;
            else if (rd_clr)  flag_d = 1'b0;
            else              flag_d = flag_q;
         end
      end else begin : g_clr_wins
         always_comb begin
            if (load)         flag_d = 1'b0;
            else if (rd_clr)  flag_d = 1'b0;
            else if (timeout) flag_d = 1'b1;
            else              flag_d = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign cnt  = cnt_q;
   assign flag = flag_q;
   assign pin  = pin_q;
endmodule

// File: rtl/latched_interval_timer.sv
module latched_interval_timer
   import lit_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        sel,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              free_run,
   input  logic              pin_en,
   input  logic              pin_dir,
   output logic              irq_flag,
   output logic              pin_level,
   output logic              pin_ovr
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   lit_sel_e          sel_e;
   logic [BYTE_W-1:0] lat_lo, lat_hi;
   logic              load, rd_clr;
   logic [CNT_W-1:0]  cnt_q;

   assign sel_e  = lit_sel_e'(sel);
   assign rd_clr = rd_en && (sel_e == SEL_CNT_LO);

   lit_latch #(.BYTE_W(BYTE_W)) u_latch (
      .clk    (clk),
      .wr_en  (wr_en),
      .sel    (sel_e),
      .wdata  (wdata),
      .lat_lo (lat_lo),
      .lat_hi (lat_hi),
      .load   (load)
   );

   lit_core #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (load),
      .load_val   ({wdata, lat_lo}),
      .reload_val ({lat_hi, lat_lo}),
      .free_run   (free_run),
      .rd_clr     (rd_clr),
      .cnt        (cnt_q),
      .flag       (irq_flag),
      .pin        (pin_level)
   );

   always_comb begin
      unique case (sel_e)
         SEL_CNT_LO: rdata = cnt_q[BYTE_W-1:0];
         SEL_CNT_HI: rdata = cnt_q[CNT_W-1:BYTE_W];
         SEL_LAT_LO: rdata = lat_lo;
         default:    rdata = lat_hi;
      endcase
   end

   assign pin_ovr = pin_en && pin_dir;
endmodule

// File: rtl/lit_chk.sv
module lit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic             rd_en,
   input logic [1:0]       sel,
   input logic             irq_flag,
   input logic             pin_level,
   input logic [CNT_W-1:0] cnt
);
   logic ld;
   assign ld = wr_en && (sel == 2'd1);

   AST_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> !irq_flag); // R3
   AST_LOAD_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> !pin_level); // R3
   AST_LATCH_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel != 2'd1 && !tick) |=> $stable(cnt)); // R2
   AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt)); // R4
   AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(tick)); // R5
   AST_IDLE_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(pin_level)); // R7
   AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == 2'd0 && !tick) |=> !irq_flag); // R8
endmodule

bind latched_interval_timer lit_chk #(.CNT_W(CNT_W)) u_lit_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .sel       (sel),
   .irq_flag  (irq_flag),
   .pin_level (pin_level),
   .cnt       (cnt_q)
);

// File: tb/test_latched_interval_timer.sv
module test_latched_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       free_run = 1'b0, pin_en = 1'b0, pin_dir = 1'b0;
   logic       irq_flag, pin_level, pin_ovr;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   latched_interval_timer i_latched_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .sel(sel), .wdata(wdata), .rdata(rdata), .free_run(free_run),
      .pin_en(pin_en), .pin_dir(pin_dir), .irq_flag(irq_flag),
      .pin_level(pin_level), .pin_ovr(pin_ovr)
   );

   // {free_run, N, expected cycles from load edge to flag}
   localparam logic [32:0] VEC [7] = '{
      {1'b0, 16'd0,   16'd1},
      {1'b0, 16'd1,   16'd2},
      {1'b0, 16'd6,   16'd7},
      {1'b0, 16'd300, 16'd301},
      {1'b1, 16'd1,   16'd2},
      {1'b1, 16'd5,   16'd6},
      {1'b1, 16'd258, 16'd259}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; sel = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_en = 1'b1; sel = a;
      #1 v = int'(rdata);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic load16(input logic [15:0] n);
      wr(2'd0, n[7:0]);
      wr(2'd1, n[15:8]);
   endtask

   task automatic wait_flag(output int edges);
      edges = 0;
      for (int i = 0; i < 1000; i++) begin
         @(posedge clk);
         @(negedge clk);
         edges++;
         if (irq_flag) return;
      end
      edges = -1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v, c;
      @(negedge clk);
      step(2);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 flag after reset", int'(irq_flag), 0);
      chk("R1 pin after reset", int'(pin_level), 1);
      tick = 1'b1;

      // table of periods: R5 single shot, R7 free run
      foreach (VEC[k]) begin
         free_run = VEC[k][32];
         load16(VEC[k][31:16]);
         wait_flag(c);
         chk(VEC[k][32] ? "R7 first period" : "R5 first time-out", c, int'(VEC[k][15:0]));
         if (VEC[k][32]) begin
            rd(2'd0, v);
            chk("R8 read clears flag", int'(irq_flag), 0);
            wait_flag(c);
            chk("R7 reload period", c + 1, int'(VEC[k][15:0]));
         end
      end

      // R2 latch writes during a count leave the counter alone
      free_run = 1'b0;
      load16(16'd200);
      wr(2'd2, 8'd5);
      wr(2'd3, 8'd0);
      rd(2'd0, v);
      chk("R2 count after latch writes", v, 198);
      rd(2'd2, v);
      chk("R8 read low latch", v, 5);
      rd(2'd3, v);
      chk("R8 read high latch", v, 0);

      // R2 + R7 new latch value only affects the next period
      free_run = 1'b1;
      load16(16'd10);
      wr(2'd2, 8'd20);
      wait_flag(c);
      chk("R2 current period kept", c + 1, 11);
      rd(2'd0, v);
      wait_flag(c);
      chk("R7 next period from new latch", c + 1, 21);

      // R8 latch reads do not clear, count-low read does
      rd(2'd2, v);
      chk("R8 latch read keeps flag", int'(irq_flag), 1);
      rd(2'd1, v);
      chk("R8 count-high read keeps flag", int'(irq_flag), 1);

      // R4 hold with tick low
      free_run = 1'b0;
      load16(16'd9);
      tick = 1'b0;
      step(5);
      rd(2'd0, v);
      chk("R4 count held", v, 9);
      tick = 1'b1;
      step(3);
      rd(2'd0, v);
      chk("R4 count decrements", v, 6);

      // R9 time-out coincides with clearing read
      load16(16'd4);
      step(4);
      chk("R9 flag before time-out", int'(irq_flag), 0);
      rd(2'd0, v);
      chk("R9 count zero at collision", v, 0);
      chk("R9 set beats clear", int'(irq_flag), 1);

      // R9 load coincides with time-out
      load16(16'd2);
      step(2);
      wr(2'd1, 8'd0);
      chk("R9 load beats time-out flag", int'(irq_flag), 0);
      rd(2'd0, v);
      chk("R9 load beats time-out count", v, 2);

      // R6 single shot wraps and never re-flags; R3 pin pulse
      pin_en = 1'b1; pin_dir = 1'b1;
      load16(16'd2);
      chk("R3 pin low after load", int'(pin_level), 0);
      wait_flag(c);
      chk("R6 pin high at time-out", int'(pin_level), 1);
      rd(2'd1, v);
      chk("R6 wrap high byte", v, 255);
      rd(2'd0, v);
      chk("R6 wrap low byte", v, 254);
      c = 0;
      for (int i = 0; i < 65540; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (irq_flag) c++;
      end
      chk("R6 no second flag", c, 0);
      chk("R6 pin stays high", int'(pin_level), 1);

      // R7 pin toggles in free run
      free_run = 1'b1;
      load16(16'd3);
      chk("R3 pin low after free load", int'(pin_level), 0);
      wait_flag(c);
      chk("R7 pin toggled high", int'(pin_level), 1);
      rd(2'd0, v);
      wait_flag(c);
      chk("R7 pin toggled low", int'(pin_level), 0);

      // R10 override truth table
      for (int i = 0; i < 4; i++) begin
         pin_en = i[0]; pin_dir = i[1];
         #1 chk("R10 override", int'(pin_ovr), (i == 3) ? 1 : 0);
      end

      // R1 reset keeps latches
      free_run = 1'b0;
      wr(2'd2, 8'h34);
      wr(2'd3, 8'h12);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      rd(2'd2, v);
      chk("R1 low latch kept", v, 8'h34);
      rd(2'd3, v);
      chk("R1 high latch kept", v, 8'h12);
      chk("R1 pin after second reset", int'(pin_level), 1);
      chk("R1 flag after second reset", int'(irq_flag), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule